// File: doc/BRIEF.md
# I2C Interrupt Flag and Status Controller

This block holds the interrupt-pending flag of an I2C controller together with the status bits that go with it: arbitration lost, received acknowledge, and the sticky START and STOP detection flags. Event pulses come in from the byte engine, address matcher, arbitration logic, SMBus timeout counters and bus-condition detectors. The block merges them into one pending flag and drives a single interrupt request, gated by an enable.

Software clears the flags through a small register write port with write-one-to-clear semantics. A fast-acknowledge mode bit chooses when a byte transfer raises the flag. With the mode bit at 0, the flag rises after the ACK/NACK bit. With the mode bit at 1, it rises after the eighth data bit, which lets software choose ACK or NACK before that bit goes out. A START or STOP flag that is still set re-raises the pending flag. Software must therefore clear the detection flag first and the pending flag after it.

Top module: `i2c_iflag_ctrl`

## Requirements
- R1: After reset, iflag_o, arbl_o, rxak_o, startf_o, stopf_o and irq_o are all 0.
- R2: A write with wr_sel_i=0 (status) and wr_data_i[1]=1 clears iflag_o on the next cycle. Writing wr_data_i[1]=0 leaves iflag_o unchanged.
- R3: With fack_i=0, an ack_done_i pulse sets iflag_o on the next cycle and a data_done_i pulse does not.
- R4: With fack_i=1, a data_done_i pulse sets iflag_o on the next cycle and an ack_done_i pulse does not.
- R5: An arb_lost_i pulse sets both iflag_o and arbl_o. A status write with wr_data_i[2]=1 clears arbl_o.
- R6: When smbus_en_i=1, tmo_evt_i[0] (clock-low timeout) sets iflag_o. tmo_evt_i[1] (clock-high timeout) and tmo_evt_i[2] (data-high timeout) never set it. No timeout sets it when smbus_en_i=0.
- R7: start_det_i sets startf_o and stop_det_i sets stopf_o, whatever the value of ss_ie_i. Either pulse sets iflag_o only when ss_ie_i=1. A write with wr_sel_i=1 (filter) clears startf_o when wr_data_i[0]=1 and clears stopf_o when wr_data_i[1]=1.
- R8: While ss_ie_i=1 and startf_o or stopf_o is 1, iflag_o is set again every cycle, so clearing it has no lasting effect. Once both detection flags are clear, a clear of iflag_o holds.
- R9: On an ack_done_i pulse, rxak_o takes the value of rx_nack_i (0 = ACK seen, 1 = no ACK). It holds that value at all other times.
- R10: When a set event and a clear write for the same bit fall in the same cycle, the bit ends up 1.
- R11: irq_o is 1 exactly when iflag_o is 1 and irq_en_i is 1.
- R12: An addr_match_i pulse sets iflag_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fack_i | input | 1 | Fast-acknowledge mode |
| data_done_i | input | 1 | Pulse: eight data bits finished |
| ack_done_i | input | 1 | Pulse: ACK/NACK bit finished |
| rx_nack_i | input | 1 | Sampled acknowledge level, valid with ack_done_i |
| addr_match_i | input | 1 | Pulse: slave address matched |
| arb_lost_i | input | 1 | Pulse: arbitration lost |
| smbus_en_i | input | 1 | SMBus mode enable |
| tmo_evt_i | input | 3 | Timeout pulses: [0] clock low, [1] clock high, [2] data high |
| start_det_i | input | 1 | Pulse: START detected |
| stop_det_i | input | 1 | Pulse: STOP detected |
| ss_ie_i | input | 1 | START/STOP interrupt enable |
| irq_en_i | input | 1 | Interrupt request enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = status register, 1 = filter register |
| wr_data_i | input | 3 | Write data, ones clear bits |
| iflag_o | output | 1 | Interrupt pending flag |
| arbl_o | output | 1 | Arbitration lost flag |
| rxak_o | output | 1 | Received acknowledge, 1 = no ACK |
| startf_o | output | 1 | START detected flag |
| stopf_o | output | 1 | STOP detected flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the re-raise: software clears iflag_o in the wrong order while a detection flag is still pending. The stimulus turns on ss_ie_i, sends a START, and issues the status clear before the filter clear. The run then checks that the flag comes back, and that it stays cleared only after the filter write. Clears that land in the same cycle as set pulses are driven on purpose, and the reference model is checked on every clock through all of this.

// File: rtl/i2c_iflag_pkg.sv
package i2c_iflag_pkg;
  typedef enum logic {SEL_STATUS = 1'b0, SEL_FILTER = 1'b1} wr_sel_e;

  localparam int WR_W         = 3;
  localparam int TMO_W        = 3;
  localparam int ST_IF_BIT    = 1;
  localparam int ST_AL_BIT    = 2;
  localparam int FL_START_BIT = 0;
  localparam int FL_STOP_BIT  = 1;

  localparam int NUM_STICKY = 4;
  localparam int IDX_IF     = 0;
  localparam int IDX_AL     = 1;
  localparam int IDX_START  = 2;
  localparam int IDX_STOP   = 3;
endpackage

// File: rtl/i2c_sticky_bit.sv
module i2c_sticky_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/i2c_evt_collect.sv
module i2c_evt_collect #(
  parameter int                TMO_W    = 3,
  parameter logic [TMO_W-1:0]  TMO_MASK = 3'b001
) (
  input  logic             fack_i,
  input  logic             data_done_i,
  input  logic             ack_done_i,
  input  logic             addr_match_i,
  input  logic             arb_lost_i,
  input  logic             smbus_en_i,
  input  logic [TMO_W-1:0] tmo_evt_i,
  input  logic             start_det_i,
  input  logic             stop_det_i,
  input  logic             ss_ie_i,
  input  logic             startf_q_i,
  input  logic             stopf_q_i,
  output logic             flag_set_o
);
  logic byte_evt, tmo_evt, bus_evt;

  always_comb begin
    byte_evt   = fack_i ? data_done_i : ack_done_i;
    tmo_evt    = smbus_en_i && |(tmo_evt_i & TMO_MASK);
    // pending detection flags keep re-raising the main flag
    bus_evt    = ss_ie_i && (start_det_i || stop_det_i || startf_q_i || stopf_q_i);
    flag_set_o = byte_evt || addr_match_i || arb_lost_i || tmo_evt || bus_evt;
  end
endmodule

// File: rtl/i2c_iflag_ctrl.sv
module i2c_iflag_ctrl
  import i2c_iflag_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fack_i,
  input  logic             data_done_i,
  input  logic             ack_done_i,
  input  logic             rx_nack_i,
  input  logic             addr_match_i,
  input  logic             arb_lost_i,
  input  logic             smbus_en_i,
  input  logic [TMO_W-1:0] tmo_evt_i,
  input  logic             start_det_i,
  input  logic             stop_det_i,
  input  logic             ss_ie_i,
  input  logic             irq_en_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [WR_W-1:0]  wr_data_i,
  output logic             iflag_o,
  output logic             arbl_o,
  output logic             rxak_o,
  output logic             startf_o,
  output logic             stopf_o,
  output logic             irq_o
);
  logic [NUM_STICKY-1:0] set_v, clr_v, q_v;
  logic flag_set, st_wr, fl_wr;

  i2c_evt_collect #(.TMO_W(TMO_W), .TMO_MASK(3'b001)) u_collect (
    .fack_i      (fack_i),
    .data_done_i (data_done_i),
    .ack_done_i  (ack_done_i),
    .addr_match_i(addr_match_i),
    .arb_lost_i  (arb_lost_i),
    .smbus_en_i  (smbus_en_i),
    .tmo_evt_i   (tmo_evt_i),
    .start_det_i (start_det_i),
    .stop_det_i  (stop_det_i),
    .ss_ie_i     (ss_ie_i),
    .startf_q_i  (q_v[IDX_START]),
    .stopf_q_i   (q_v[IDX_STOP]),
    .flag_set_o  (flag_set)
  );

  always_comb begin
    st_wr = wr_en_i && (wr_sel_i == SEL_STATUS);
    fl_wr = wr_en_i && (wr_sel_i == SEL_FILTER);
    set_v[IDX_IF]    = flag_set;
    set_v[IDX_AL]    = arb_lost_i;
    set_v[IDX_START] = start_det_i;
    set_v[IDX_STOP]  = stop_det_i;
    clr_v[IDX_IF]    = st_wr && wr_data_i[ST_IF_BIT];
    clr_v[IDX_AL]    = st_wr && wr_data_i[ST_AL_BIT];
    clr_v[IDX_START] = fl_wr && wr_data_i[FL_START_BIT];
    clr_v[IDX_STOP]  = fl_wr && wr_data_i[FL_STOP_BIT];
  end

  for (genvar g = 0; g < NUM_STICKY; g++) begin : g_sticky
    i2c_sticky_bit u_bit (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_v[g]),
      .clr_i (clr_v[g]),
      .q_o   (q_v[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rxak_o <= 1'b0;
    else if (ack_done_i) rxak_o <= rx_nack_i;
  end

  assign iflag_o  = q_v[IDX_IF];
  assign arbl_o   = q_v[IDX_AL];
  assign startf_o = q_v[IDX_START];
  assign stopf_o  = q_v[IDX_STOP];
  assign irq_o    = iflag_o && irq_en_i;
endmodule

// File: rtl/i2c_iflag_ctrl_chk.sv
module i2c_iflag_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       fack_i,
  input logic       data_done_i,
  input logic       ack_done_i,
  input logic       rx_nack_i,
  input logic       addr_match_i,
  input logic       arb_lost_i,
  input logic       smbus_en_i,
  input logic [2:0] tmo_evt_i,
  input logic       start_det_i,
  input logic       stop_det_i,
  input logic       ss_ie_i,
  input logic       wr_en_i,
  input logic       wr_sel_i,
  input logic [2:0] wr_data_i,
  input logic       iflag_o,
  input logic       arbl_o,
  input logic       rxak_o,
  input logic       startf_o,
  input logic       stopf_o
);
  logic any_set;
  assign any_set = data_done_i || ack_done_i || addr_match_i || arb_lost_i ||
                   (smbus_en_i && tmo_evt_i[0]) ||
                   (ss_ie_i && (start_det_i || stop_det_i || startf_o || stopf_o));

  a_r3_ack_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fack_i && ack_done_i) |=> iflag_o);
  a_r4_fack_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fack_i && data_done_i) |=> iflag_o);
  a_r5_arb_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_lost_i |=> (iflag_o && arbl_o));
  a_r7_start_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det_i |=> startf_o);
  a_r7_stop_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det_i |=> stopf_o);
  a_r8_reraise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_ie_i && (startf_o || stopf_o)) |=> iflag_o);
  a_r9_rxak_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_done_i |=> (rxak_o == $past(rx_nack_i)));
  a_r9_rxak_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_done_i |=> $stable(rxak_o));
  a_r2_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i && wr_data_i[1] && !any_set) |=> !iflag_o);
  a_r2_w0_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iflag_o && !(wr_en_i && !wr_sel_i && wr_data_i[1])) |=> iflag_o);
endmodule

bind i2c_iflag_ctrl i2c_iflag_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fack_i(fack_i), .data_done_i(data_done_i),
  .ack_done_i(ack_done_i), .rx_nack_i(rx_nack_i), .addr_match_i(addr_match_i),
  .arb_lost_i(arb_lost_i), .smbus_en_i(smbus_en_i), .tmo_evt_i(tmo_evt_i),
  .start_det_i(start_det_i), .stop_det_i(stop_det_i), .ss_ie_i(ss_ie_i),
  .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
  .iflag_o(iflag_o), .arbl_o(arbl_o), .rxak_o(rxak_o),
  .startf_o(startf_o), .stopf_o(stopf_o)
);

// File: tb/i2c_iflag_ctrl_test.sv
module i2c_iflag_ctrl_test;
  logic clk = 0, rst_ni = 0;
  logic fack = 0, data_done = 0, ack_done = 0, rx_nack = 0, addr_match = 0, arb_lost = 0;
  logic smbus_en = 0, start_det = 0, stop_det = 0, ss_ie = 0, irq_en = 0;
  logic wr_en = 0, wr_sel = 0;
  logic [2:0] tmo = 0, wr_data = 0;
  logic iflag, arbl, rxak, startf, stopf, irq;

  int errors = 0, checks = 0;
  bit m_if, m_al, m_rx, m_sf, m_pf;

  always #2.5 clk = ~clk;

  i2c_iflag_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .fack_i(fack), .data_done_i(data_done),
    .ack_done_i(ack_done), .rx_nack_i(rx_nack), .addr_match_i(addr_match),
    .arb_lost_i(arb_lost), .smbus_en_i(smbus_en), .tmo_evt_i(tmo),
    .start_det_i(start_det), .stop_det_i(stop_det), .ss_ie_i(ss_ie),
    .irq_en_i(irq_en), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .iflag_o(iflag), .arbl_o(arbl), .rxak_o(rxak), .startf_o(startf),
    .stopf_o(stopf), .irq_o(irq)
  );

  task automatic chk(string tag, string nm, logic act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "iflag", iflag, m_if);
    chk(tag, "arbl", arbl, m_al);
    chk(tag, "rxak", rxak, m_rx);
    chk(tag, "startf", startf, m_sf);
    chk(tag, "stopf", stopf, m_pf);
    chk({tag, "/R11"}, "irq", irq, m_if && irq_en);
  endtask

  // model the clock edge from the currently driven inputs, then compare
  task automatic tick(string tag);
    bit s_if, c_if, c_al, c_sf, c_pf;
    @(posedge clk);
    s_if = (fack ? data_done : ack_done) || addr_match || arb_lost ||
           (smbus_en && tmo[0]) ||
           (ss_ie && (start_det || stop_det || m_sf || m_pf));
    c_if = wr_en && !wr_sel && wr_data[1];
    c_al = wr_en && !wr_sel && wr_data[2];
    c_sf = wr_en &&  wr_sel && wr_data[0];
    c_pf = wr_en &&  wr_sel && wr_data[1];
    m_if = s_if ? 1'b1 : (c_if ? 1'b0 : m_if);
    m_al = arb_lost ? 1'b1 : (c_al ? 1'b0 : m_al);
    m_sf = start_det ? 1'b1 : (c_sf ? 1'b0 : m_sf);
    m_pf = stop_det ? 1'b1 : (c_pf ? 1'b0 : m_pf);
    if (ack_done) m_rx = rx_nack;
    @(negedge clk);
    compare(tag);
    data_done = 0; ack_done = 0; addr_match = 0; arb_lost = 0; tmo = 0;
    start_det = 0; stop_det = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
  endtask

  task automatic wr(bit sel, logic [2:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
  endtask

  task automatic clear_all(string tag);
    wr(1, 3'b011); tick(tag);
    wr(0, 3'b110); tick(tag);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_ni = 1;
    @(negedge clk);
    compare("R1");
    irq_en = 1;

    // R3: normal mode, byte flag after ACK bit
    data_done = 1; tick("R3"); tick("R3");
    ack_done = 1; rx_nack = 1; tick("R3"); tick("R9");
    wr(0, 3'b000); tick("R2");          // write 0: no effect
    wr(0, 3'b010); tick("R2");          // write 1: clears
    irq_en = 0; ack_done = 1; rx_nack = 0; tick("R11"); irq_en = 1; tick("R11");
    wr(0, 3'b010); tick("R2");

    // R4: fast-ACK mode
    fack = 1;
    ack_done = 1; rx_nack = 1; tick("R4"); tick("R9");
    data_done = 1; tick("R4");
    wr(0, 3'b010); tick("R2");
    fack = 0;

    // R12 address match
    addr_match = 1; tick("R12");
    wr(0, 3'b010); tick("R12");

    // R5 arbitration
    arb_lost = 1; tick("R5");
    wr(0, 3'b010); tick("R5");
    wr(0, 3'b100); tick("R5");

    // R6 timeouts
    tmo = 3'b001; tick("R6");
    smbus_en = 1;
    tmo = 3'b110; tick("R6"); tick("R6");
    tmo = 3'b001; tick("R6");
    wr(0, 3'b010); tick("R6");
    smbus_en = 0;

    // R7 start/stop, enable off: sticky only
    start_det = 1; tick("R7");
    stop_det = 1; tick("R7");
    wr(1, 3'b001); tick("R7");
    wr(1, 3'b010); tick("R7");

    // R8 wrong clear order re-raises
    ss_ie = 1;
    start_det = 1; tick("R8");
    wr(0, 3'b010); tick("R8"); tick("R8");
    wr(1, 3'b001); tick("R8");
    wr(0, 3'b010); tick("R8"); tick("R8");
    stop_det = 1; tick("R8");
    wr(1, 3'b010); tick("R8");
    wr(0, 3'b010); tick("R8");
    ss_ie = 0;

    // R10 set beats same-cycle clear
    wr(0, 3'b110); arb_lost = 1; tick("R10");
    wr(1, 3'b011); start_det = 1; stop_det = 1; tick("R10");
    wr(0, 3'b010); addr_match = 1; tick("R10");
    clear_all("R10");
    tick("R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule